// File: doc/BRIEF.md
# Relative-Age LRU Replacement Tracker

This block keeps least-recently-used order for a group of cache sets, each set holding four ways. For every way of every set it stores a 2-bit relative age, where 0 marks the most recently touched way and 3 the least recently touched. The four ages inside one set are always a permutation of 0..3, so the set's full recency order is kept exactly, with no tree approximation.

The cache controller presents one access per cycle. Each access names a set, says whether it hit, and gives the hit way or the way being filled on a miss. The touched way becomes youngest. Only the ways that were younger than it move one step older, and the rest keep their ages. For the addressed set, the block also gives the way to replace, chosen from the valid bits the controller supplies. If any way is empty, the lowest-numbered empty way is chosen. If all ways are valid, the oldest way is chosen. Both outputs depend combinationally on the addressed set, so the controller can read the victim in the same cycle it looks up the tags.

Top module: `lru_age_tracker`

## Requirements
- R1: The four ages of a set are always distinct and take the values 0..3. `ages_o` bits [2w+1:2w] carry the age of way w, where 0 is youngest and 3 is oldest.
- R2: An access with `acc_hit`=1 sets the hit way's age to 0 in the next cycle. Ways whose age was below the hit way's old age gain 1, and every other way keeps its age.
- R3: An access with `acc_hit`=0 fills `fill_way`. That way's age becomes 0, ways younger than its old age gain 1, and the other ways are unchanged. No age ever goes past 3.
- R4: When all four `line_valid` bits are 1, `victim_way` is the way of the addressed set whose age is 3.
- R5: When any `line_valid` bit is 0, `victim_way` is the lowest-numbered way whose valid bit is 0, whatever the ages are.
- R6: A cycle with `acc_vld`=0 leaves every age unchanged, whatever the hit flag, hit way, fill way and valid inputs are.
- R7: Starting from reset, the set goes through fill way 0, fill way 1, hit way 0, fill way 2, hit way 0, fill way 3 and hit way 0. After this, the ages of ways 0..3 are 0, 3, 2, 1 and, with all ways valid, `victim_way` is 1.
- R8: After reset, every set holds age w for way w (0, 1, 2, 3).
- R9: An access changes only the ages of the set named by `acc_set`. All other sets are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 1 | An access to the addressed set occurs this cycle |
| acc_set | input | 2 | Set index for the access and for the outputs |
| acc_hit | input | 1 | 1: the access hit; 0: it missed and fills `fill_way` |
| acc_hit_way | input | 2 | Way that hit |
| fill_way | input | 2 | Way being filled on a miss |
| line_valid | input | 4 | Valid bit of each way of the addressed set |
| victim_way | output | 2 | Way to replace in the addressed set |
| ages_o | output | 8 | Relative ages of the addressed set, 2 bits per way |

## Verification
The hardest state to reach from the ports is a full set whose age-3 way is not way 3, while hits keep landing on ways of middle age. In that state the selective increment and the oldest-way victim choice are both exercised, and neither is the trivial case. The stimulus gets there with the scripted cold-start sequence and then with a long random phase. In that phase most misses fill the way the reference model names as victim, which keeps sets full and mixes their order. Set isolation is checked by hammering one set while another, left untouched, is read back afterwards.

// File: rtl/lru_pkg.sv
package lru_pkg;
  localparam int unsigned LRU_WAYS_DEF = 4;
  localparam int unsigned LRU_SETS_DEF = 4;

  typedef enum logic [1:0] {
    TOUCH_NONE = 2'd0,
    TOUCH_HIT  = 2'd1,
    TOUCH_FILL = 2'd2
  } touch_kind_e;
endpackage

// File: rtl/lru_age_update.sv
module lru_age_update #(
  parameter int unsigned WAYS  = lru_pkg::LRU_WAYS_DEF,
  parameter int unsigned AGE_W = $clog2(WAYS),
  parameter int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                        en,
  input  logic [WAY_W-1:0]            touch_way,
  input  logic [WAYS-1:0][AGE_W-1:0]  age_cur,
  output logic [WAYS-1:0][AGE_W-1:0]  age_nxt
);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [AGE_W-1:0] ref_age;

  assign ref_age = age_cur[touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_comb begin
      age_nxt[w] = age_cur[w];
      if (en) begin
        if (touch_way == WAY_W'(w)) begin
          age_nxt[w] = '0;
        end else if (age_cur[w] < ref_age) begin
          age_nxt[w] = (age_cur[w] == AGE_MAX) ? AGE_MAX : age_cur[w] + AGE_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/lru_victim_sel.sv
module lru_victim_sel #(
  parameter int unsigned WAYS  = lru_pkg::LRU_WAYS_DEF,
  parameter int unsigned AGE_W = $clog2(WAYS),
  parameter int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][AGE_W-1:0]  age_cur,
  input  logic [WAYS-1:0]             valid,
  output logic [WAY_W-1:0]            victim
);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(WAYS - 1);

  logic [WAY_W-1:0] empty_way;
  logic [WAY_W-1:0] oldest_way;

  always_comb begin
    empty_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) empty_way = WAY_W'(w);
    end
  end

  always_comb begin
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_cur[w] == AGE_MAX) oldest_way = WAY_W'(w);
    end
  end

  assign victim = (&valid) ? oldest_way : empty_way;
endmodule

// File: rtl/lru_age_tracker.sv
module lru_age_tracker #(
  parameter int unsigned WAYS     = lru_pkg::LRU_WAYS_DEF,
  parameter int unsigned NUM_SETS = lru_pkg::LRU_SETS_DEF,
  localparam int unsigned AGE_W   = $clog2(WAYS),
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_vld,
  input  logic [SET_W-1:0]        acc_set,
  input  logic                    acc_hit,
  input  logic [WAY_W-1:0]        acc_hit_way,
  input  logic [WAY_W-1:0]        fill_way,
  input  logic [WAYS-1:0]         line_valid,
  output logic [WAY_W-1:0]        victim_way,
  output logic [WAYS*AGE_W-1:0]   ages_o
);
  import lru_pkg::*;

  touch_kind_e                kind;
  logic [WAY_W-1:0]           touch_way;
  logic                       touch_en;
  logic [NUM_SETS-1:0]        set_we;
  logic [WAYS-1:0][AGE_W-1:0] age_all [NUM_SETS];
  logic [WAYS-1:0][AGE_W-1:0] age_cur;
  logic [WAYS-1:0][AGE_W-1:0] age_nxt;

  // Classify the access and pick the way being touched
  always_comb begin
    if (!acc_vld)     kind = TOUCH_NONE;
    else if (acc_hit) kind = TOUCH_HIT;
    else              kind = TOUCH_FILL;
  end

  assign touch_en  = (kind != TOUCH_NONE);
  assign touch_way = (kind == TOUCH_HIT) ? acc_hit_way : fill_way;

  always_comb begin
    for (int s = 0; s < NUM_SETS; s++) begin
      set_we[s] = touch_en && (acc_set == SET_W'(s));
    end
  end

  assign age_cur = age_all[acc_set];

  lru_age_update #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_update (
    .en        (touch_en),
    .touch_way (touch_way),
    .age_cur   (age_cur),
    .age_nxt   (age_nxt)
  );

  lru_victim_sel #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) u_victim (
    .age_cur (age_cur),
    .valid   (line_valid),
    .victim  (victim_way)
  );

  // Per-set age storage with its own write enable
  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic [WAYS-1:0][AGE_W-1:0] age_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WAYS; w++) age_r[w] <= AGE_W'(w);
      end else if (set_we[s]) begin
        age_r <= age_nxt;
      end
    end

    assign age_all[s] = age_r;
  end

  assign ages_o = age_cur;
endmodule

// File: rtl/lru_age_chk.sv
module lru_age_chk #(
  parameter int unsigned WAYS     = 4,
  parameter int unsigned NUM_SETS = 4,
  localparam int unsigned AGE_W   = $clog2(WAYS),
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_vld,
  input logic [SET_W-1:0]      acc_set,
  input logic                  acc_hit,
  input logic [WAY_W-1:0]      acc_hit_way,
  input logic [WAY_W-1:0]      fill_way,
  input logic [WAYS-1:0]       line_valid,
  input logic [WAY_W-1:0]      victim_way,
  input logic [WAYS*AGE_W-1:0] ages_o
);
  logic [WAYS-1:0]       seen;
  logic [WAYS-1:0]       low_mask;
  logic                  armed;
  logic                  prev_vld;
  logic                  prev_hit;
  logic [SET_W-1:0]      prev_set;
  logic [WAY_W-1:0]      prev_touch;
  logic [WAYS*AGE_W-1:0] prev_ages;

  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[ages_o[w*AGE_W +: AGE_W]] = 1'b1;
  end

  assign low_mask = (WAYS'(1) << victim_way) - WAYS'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed      <= 1'b0;
      prev_vld   <= 1'b0;
      prev_hit   <= 1'b0;
      prev_set   <= '0;
      prev_touch <= '0;
      prev_ages  <= '0;
    end else begin
      armed      <= 1'b1;
      prev_vld   <= acc_vld;
      prev_hit   <= acc_hit;
      prev_set   <= acc_set;
      prev_touch <= acc_hit ? acc_hit_way : fill_way;
      prev_ages  <= ages_o;
    end
  end

  // R1
  ages_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);

  // R2
  hit_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_vld && prev_hit && acc_set == prev_set)
      |-> ages_o[prev_touch*AGE_W +: AGE_W] == '0);

  // R3
  fill_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && prev_vld && !prev_hit && acc_set == prev_set)
      |-> ages_o[prev_touch*AGE_W +: AGE_W] == '0);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !prev_vld && acc_set == prev_set) |-> ages_o == prev_ages);

  // R4
  oldest_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&line_valid) |-> ages_o[victim_way*AGE_W +: AGE_W] == AGE_W'(WAYS - 1));

  // R5
  first_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&line_valid) |-> (!line_valid[victim_way] && ((line_valid & low_mask) == low_mask)));
endmodule

bind lru_age_tracker lru_age_chk #(.WAYS(WAYS), .NUM_SETS(NUM_SETS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .acc_vld     (acc_vld),
  .acc_set     (acc_set),
  .acc_hit     (acc_hit),
  .acc_hit_way (acc_hit_way),
  .fill_way    (fill_way),
  .line_valid  (line_valid),
  .victim_way  (victim_way),
  .ages_o      (ages_o)
);

// File: tb/tb_lru_age_tracker.sv
module tb_lru_age_tracker;
  localparam int CLK_P    = 10;
  localparam int WAYS     = 4;
  localparam int NUM_SETS = 4;

  logic       clk;
  logic       rst_n;
  logic       acc_vld;
  logic [1:0] acc_set;
  logic       acc_hit;
  logic [1:0] acc_hit_way;
  logic [1:0] fill_way;
  logic [3:0] line_valid;
  logic [1:0] victim_way;
  logic [7:0] ages_o;

  lru_age_tracker #(.WAYS(WAYS), .NUM_SETS(NUM_SETS)) dut (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
    .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .fill_way(fill_way),
    .line_valid(line_valid), .victim_way(victim_way), .ages_o(ages_o)
  );

  // Reference: recency list per set, position 0 = most recent
  int    order [NUM_SETS][WAYS];
  int    vectors = 0;
  int    miscompares = 0;
  string last_tag = "R8";

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int ref_age(int s, int w);
    for (int p = 0; p < WAYS; p++) if (order[s][p] == w) return p;
    return -1;
  endfunction

  function automatic int ref_victim(int s, logic [3:0] v);
    for (int w = 0; w < WAYS; w++) if (!v[w]) return w;
    return order[s][WAYS-1];
  endfunction

  task automatic touch(int s, int w);
    int p;
    p = ref_age(s, w);
    for (int i = p; i > 0; i--) order[s][i] = order[s][i-1];
    order[s][0] = w;
  endtask

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_now();
    for (int w = 0; w < WAYS; w++)
      check(last_tag, int'(ages_o[w*2 +: 2]), ref_age(int'(acc_set), w));
    check((&line_valid) ? "R4" : "R5", int'(victim_way),
          ref_victim(int'(acc_set), line_valid));
  endtask

  task automatic step(bit v, int s, bit h, int hw, int fw, logic [3:0] val);
    @(negedge clk);
    acc_vld     = v;
    acc_set     = 2'(s);
    acc_hit     = h;
    acc_hit_way = 2'(hw);
    fill_way    = 2'(fw);
    line_valid  = val;
    #1;
    compare_now();
    if (v) begin
      touch(s, h ? hw : fw);
      last_tag = h ? "R2" : "R3";
    end else begin
      last_tag = "R6";
    end
  endtask

  task automatic peek_expect(string tag, int s, int a0, int a1, int a2, int a3, int vic);
    @(negedge clk);
    acc_vld    = 1'b0;
    acc_set    = 2'(s);
    line_valid = 4'hF;
    #1;
    check(tag, int'(ages_o[1:0]), a0);
    check(tag, int'(ages_o[3:2]), a1);
    check(tag, int'(ages_o[5:4]), a2);
    check(tag, int'(ages_o[7:6]), a3);
    if (vic >= 0) check(tag, int'(victim_way), vic);
    last_tag = "R6";
  endtask

  initial begin
    #(CLK_P * 150000);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int s = 0; s < NUM_SETS; s++)
      for (int w = 0; w < WAYS; w++) order[s][w] = w;
    rst_n = 1'b0; acc_vld = 1'b0; acc_set = '0; acc_hit = 1'b0;
    acc_hit_way = '0; fill_way = '0; line_valid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: reset ages in every set
    for (int s = 0; s < NUM_SETS; s++) peek_expect("R8", s, 0, 1, 2, 3, 3);

    // R7: cold-start sequence on set 1
    step(1, 1, 0, 0, 0, 4'b0000);
    step(1, 1, 0, 0, 1, 4'b0001);
    step(1, 1, 1, 0, 0, 4'b0011);
    step(1, 1, 0, 0, 2, 4'b0011);
    step(1, 1, 1, 0, 0, 4'b0111);
    step(1, 1, 0, 0, 3, 4'b0111);
    step(1, 1, 1, 0, 0, 4'b1111);
    peek_expect("R7", 1, 0, 3, 2, 1, 1);

    // R6: idle cycles with noisy side inputs leave set 1 alone
    for (int i = 0; i < 8; i++)
      step(0, 1, 1'($urandom), int'($urandom % 4), int'($urandom % 4), 4'($urandom));
    peek_expect("R6", 1, 0, 3, 2, 1, 1);

    // R9: hammer set 2, set 0 must still hold its reset ages
    for (int i = 0; i < 24; i++)
      step(1, 2, 1'($urandom), int'($urandom % 4), int'($urandom % 4), 4'hF);
    peek_expect("R9", 0, 0, 1, 2, 3, 3);

    // Random mix across sets, mostly filling the predicted victim
    for (int i = 0; i < 3000; i++) begin
      int s;
      logic [3:0] val;
      int fw;
      s   = int'($urandom % NUM_SETS);
      val = ($urandom % 2 == 0) ? 4'hF : 4'($urandom);
      fw  = ($urandom % 10 < 7) ? ref_victim(s, val) : int'($urandom % 4);
      step(($urandom % 5) != 0, s, 1'($urandom), int'($urandom % 4), fw, val);
    end
    step(0, 0, 0, 0, 0, 4'hF);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule